// File: doc/BRIEF.md
# Sensor frame timing sequencer

This block produces the per-frame timing of a streaming image sensor. Each frame runs through four phases in a fixed order: exposure, frame overhead, line-by-line readout, then an inter-frame delay. When the run enable is still high at the end of the delay, the next frame starts on the next cycle. The block counts master-clock cycles in every phase except the delay. The delay counts single-cycle ticks from an 8 ns time base, so the whole design stays in one clock domain.

The phase lengths come from the programmed settings. An output mode m gives a resolution ratio of 2^m, because 16 >> m sensor outputs are active. A readout line lasts 129·2^m cycles. The overhead phase lasts (overhead value + 2·2^m)·129 cycles, and the overhead value resets to 10. All settings are captured when a frame starts, so a change made during a frame only affects the next frame. The block also reports the bit-width mode that was captured for the current frame. It counts whatever master clock it is given.

Top module: `frame_timer`

## Requirements
- R1: After reset the phase output is IDLE (code 0), frameStart and lineStrobe are low, and the overhead value is 10.
- R2: Phase codes are IDLE=0, EXPOSE=1, OVERHEAD=2, READOUT=3, DELAY=4. With runEn high in IDLE, the block enters EXPOSE on the next edge. It then passes through OVERHEAD, READOUT and DELAY in that order. frameStart is high for exactly the first cycle of each EXPOSE.
- R3: EXPOSE lasts expCycles cycles. A value of 0 gives one cycle.
- R4: OVERHEAD lasts (ovh + 2·2^m)·129 cycles, where m is outMode (values above 4 are treated as 4) and ovh is the value last written through ovhWe/ovhWdata.
- R5: READOUT lasts lineCount·129·2^m cycles. lineStrobe pulses for one cycle at the first cycle of each line, lineCount times per frame. A lineCount of 0 gives one READOUT cycle with no strobe.
- R6: DELAY ends on the cycle in which the trigPeriod-th tickEn pulse of that phase is seen. A trigPeriod of 0 gives one cycle.
- R7: If runEn is high in the last DELAY cycle, EXPOSE of the next frame follows directly. If runEn is low, the phase returns to IDLE after the current frame has completed.
- R8: expCycles, outMode, lineCount, trigPeriod and the overhead value are captured on entry to EXPOSE. Changes made later take effect only at the next frame.
- R9: bitModeOut shows bitModeIn as captured on entry to EXPOSE and stays constant for the rest of the frame.
- R10: A write through ovhWe replaces the reset value of the overhead, and the new value applies from the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Streaming enable |
| tickEn | input | 1 | Single-cycle 8 ns time-base tick |
| expCycles | input | 20 | Exposure length in cycles |
| ovhWe | input | 1 | Write strobe for the overhead value |
| ovhWdata | input | 8 | New overhead value |
| outMode | input | 3 | Output mode m (ratio 2^m) |
| lineCount | input | 12 | Lines per frame |
| trigPeriod | input | 16 | Inter-frame delay in ticks |
| bitModeIn | input | 1 | Bit-width mode selection |
| phase | output | 3 | Current phase code |
| frameStart | output | 1 | Pulse on the first EXPOSE cycle |
| lineStrobe | output | 1 | Pulse on the first cycle of each line |
| bitModeOut | output | 1 | Bit-width mode captured for this frame |

## Verification
Every internal fault in this block shows up as a phase boundary that moves. A counter loaded with the wrong value, or a wrong shift of the line unit, changes the length of one phase. That difference appears at the phase port in the same frame, at the first boundary after the fault, so the bench measures each phase length in cycles and does not only check the frame total. A wrong latching point appears only in the frame after a setting has changed. For that reason the bench changes the settings during the first cycle of exposure and then measures two frames in a row.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_EXPOSE   = 3'd1,
    PH_OVERHEAD = 3'd2,
    PH_READOUT  = 3'd3,
    PH_DELAY    = 3'd4
  } phase_e;

  // strobes from control to datapath, each valid on the edge that enters a phase
  typedef struct packed {
    logic startFrame;
    logic loadOvh;
    logic loadRead;
    logic loadDly;
  } ctrlCmd_t;
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runEn,
  input  logic     phaseDone,
  output phase_e   phaseQ,
  output ctrlCmd_t cmd,
  output logic     frameStartQ
);
  phase_e phaseNxt;

  always_comb begin
    phaseNxt = phaseQ;
    cmd      = '0;
    unique case (phaseQ)
      PH_IDLE: if (runEn) begin
        phaseNxt       = PH_EXPOSE;
        cmd.startFrame = 1'b1;
      end
      PH_EXPOSE: if (phaseDone) begin
        phaseNxt    = PH_OVERHEAD;
        cmd.loadOvh = 1'b1;
      end
      PH_OVERHEAD: if (phaseDone) begin
        phaseNxt     = PH_READOUT;
        cmd.loadRead = 1'b1;
      end
      PH_READOUT: if (phaseDone) begin
        phaseNxt    = PH_DELAY;
        cmd.loadDly = 1'b1;
      end
      PH_DELAY: if (phaseDone) begin
        if (runEn) begin
          phaseNxt       = PH_EXPOSE;
          cmd.startFrame = 1'b1;
        end else begin
          phaseNxt = PH_IDLE;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ      <= PH_IDLE;
      frameStartQ <= 1'b0;
    end else begin
      phaseQ      <= phaseNxt;
      frameStartQ <= cmd.startFrame;
    end
  end
endmodule

// File: rtl/fts_dp.sv
module fts_dp
  import fts_pkg::*;
#(
  parameter int EXP_W       = 20,
  parameter int OVH_W       = 8,
  parameter int MODE_W      = 3,
  parameter int LINE_W      = 12,
  parameter int TRIG_W      = 16,
  parameter int CNT_W       = 24,
  parameter int LINE_UNIT   = 129,
  parameter int OVH_DEFAULT = 10,
  parameter int MAX_MODE    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  phase_e            phase,
  input  ctrlCmd_t          cmd,
  input  logic              tickEn,
  input  logic [EXP_W-1:0]  expIn,
  input  logic              ovhWe,
  input  logic [OVH_W-1:0]  ovhWdata,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [LINE_W-1:0] linesIn,
  input  logic [TRIG_W-1:0] trigIn,
  input  logic              bitModeIn,
  output logic              phaseDone,
  output logic              lineStrobe,
  output logic              bitModeOut
);
  localparam logic [MODE_W-1:0] MODE_CAP = MODE_W'(MAX_MODE);
  localparam logic [CNT_W-1:0]  UNIT     = CNT_W'(LINE_UNIT);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  logic [OVH_W-1:0]  ovhReg, ovhLat;
  logic [MODE_W-1:0] modeLat, modeClamp;
  logic [LINE_W-1:0] linesLat, rowsLeft;
  logic [TRIG_W-1:0] trigLat;
  logic              bitLat;
  logic [CNT_W-1:0]  cnt, pos;
  logic [CNT_W-1:0]  ratioLat, lineLen, ovhLen;
  logic              step, lineEnd;

  assign modeClamp = (modeIn > MODE_CAP) ? MODE_CAP : modeIn;
  assign ratioLat  = ONE << modeLat;
  assign lineLen   = UNIT << modeLat;
  assign ovhLen    = (CNT_W'(ovhLat) + (ratioLat << 1)) * UNIT;
  assign step      = (phase != PH_DELAY) || tickEn;
  assign lineEnd   = (pos == lineLen - ONE);

  // programmable overhead value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ovhReg <= OVH_W'(OVH_DEFAULT);
    else if (ovhWe) ovhReg <= ovhWdata;
  end

  // per-frame capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovhLat   <= '0;
      modeLat  <= '0;
      linesLat <= '0;
      trigLat  <= '0;
      bitLat   <= 1'b0;
    end else if (cmd.startFrame) begin
      ovhLat   <= ovhReg;
      modeLat  <= modeClamp;
      linesLat <= linesIn;
      trigLat  <= trigIn;
      bitLat   <= bitModeIn;
    end
  end

  // phase counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      pos      <= '0;
      rowsLeft <= '0;
    end else if (cmd.startFrame) begin
      cnt <= CNT_W'(expIn);
    end else if (cmd.loadOvh) begin
      cnt <= ovhLen;
    end else if (cmd.loadRead) begin
      pos      <= '0;
      rowsLeft <= linesLat;
    end else if (cmd.loadDly) begin
      cnt <= CNT_W'(trigLat);
    end else if (phase == PH_READOUT) begin
      if (lineEnd) begin
        pos <= '0;
        if (rowsLeft != '0) rowsLeft <= rowsLeft - LINE_W'(1);
      end else begin
        pos <= pos + ONE;
      end
    end else if (step && cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  always_comb begin
    if (phase == PH_READOUT)
      phaseDone = (rowsLeft == '0) || (rowsLeft == LINE_W'(1) && lineEnd);
    else if (phase == PH_IDLE)
      phaseDone = 1'b0;
    else
      phaseDone = (cnt == '0) || (step && cnt == ONE);
  end

  assign lineStrobe = (phase == PH_READOUT) && (pos == '0) && (rowsLeft != '0);
  assign bitModeOut = bitLat;
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import fts_pkg::*;
#(
  parameter int EXP_W  = 20,
  parameter int OVH_W  = 8,
  parameter int MODE_W = 3,
  parameter int LINE_W = 12,
  parameter int TRIG_W = 16,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              tickEn,
  input  logic [EXP_W-1:0]  expCycles,
  input  logic              ovhWe,
  input  logic [OVH_W-1:0]  ovhWdata,
  input  logic [MODE_W-1:0] outMode,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [TRIG_W-1:0] trigPeriod,
  input  logic              bitModeIn,
  output logic [2:0]        phase,
  output logic              frameStart,
  output logic              lineStrobe,
  output logic              bitModeOut
);
  phase_e   phaseQ;
  ctrlCmd_t cmd;
  logic     phaseDone;

  fts_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .phaseDone(phaseDone),
    .phaseQ(phaseQ), .cmd(cmd), .frameStartQ(frameStart)
  );

  fts_dp #(
    .EXP_W(EXP_W), .OVH_W(OVH_W), .MODE_W(MODE_W),
    .LINE_W(LINE_W), .TRIG_W(TRIG_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .phase(phaseQ), .cmd(cmd), .tickEn(tickEn),
    .expIn(expCycles), .ovhWe(ovhWe), .ovhWdata(ovhWdata), .modeIn(outMode),
    .linesIn(lineCount), .trigIn(trigPeriod), .bitModeIn(bitModeIn),
    .phaseDone(phaseDone), .lineStrobe(lineStrobe), .bitModeOut(bitModeOut)
  );

  assign phase = phaseQ;
endmodule

// File: rtl/fts_checker.sv
module fts_checker (
  input logic       clk,
  input logic       rstN,
  input logic       runEn,
  input logic [2:0] phase,
  input logic       frameStart,
  input logic       lineStrobe,
  input logic       bitModeOut
);
  p_idle_in_reset_r1: assert property (@(posedge clk) !rstN |=> phase == 3'd0);

  p_start_on_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (phase == 3'd1 && $past(phase) != 3'd1));

  p_entry_has_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) != 3'd1 && phase == 3'd1) |-> frameStart);

  p_expose_to_ovh_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == 3'd1 && phase != 3'd1) |-> phase == 3'd2);

  p_ovh_to_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == 3'd2 && phase != 3'd2) |-> phase == 3'd3);

  p_read_to_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == 3'd3 && phase != 3'd3) |-> phase == 3'd4);

  p_strobe_in_readout_r5: assert property (@(posedge clk) disable iff (!rstN)
    lineStrobe |-> phase == 3'd3);

  p_stop_to_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == 3'd4 && phase != 3'd4 && !$past(runEn)) |-> phase == 3'd0);

  p_stream_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == 3'd4 && phase != 3'd4 && $past(runEn)) |-> phase == 3'd1);

  p_bitmode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |-> $stable(bitModeOut));
endmodule

bind frame_timer fts_checker u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .phase(phase),
  .frameStart(frameStart), .lineStrobe(lineStrobe), .bitModeOut(bitModeOut)
);

// File: tb/sim_frame_timer.sv
module sim_frame_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        tickEn = 1'b0;
  logic [19:0] expCycles = '0;
  logic        ovhWe = 1'b0;
  logic [7:0]  ovhWdata = '0;
  logic [2:0]  outMode = '0;
  logic [11:0] lineCount = '0;
  logic [15:0] trigPeriod = '0;
  logic        bitModeIn = 1'b0;
  logic [2:0]  phase;
  logic        frameStart, lineStrobe, bitModeOut;

  int nChecks = 0, nErr = 0;
  int tickDiv = 1, tickCnt = 0;
  int cE, cO, cR, cD, strobes, ticks, cycles;
  logic bitSeen;

  // columns: exposure, doWrite, overhead, mode, lines, trigger, expected frame total
  localparam int VEC [4][7] = '{
    '{5,  0, 10, 0, 2, 3, 1814},
    '{20, 1, 1,  2, 3, 1, 2730},
    '{0,  1, 0,  4, 1, 0, 6194},
    '{7,  1, 3,  1, 0, 2, 913}
  };

  frame_timer u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .tickEn(tickEn), .expCycles(expCycles),
    .ovhWe(ovhWe), .ovhWdata(ovhWdata), .outMode(outMode), .lineCount(lineCount),
    .trigPeriod(trigPeriod), .bitModeIn(bitModeIn), .phase(phase),
    .frameStart(frameStart), .lineStrobe(lineStrobe), .bitModeOut(bitModeOut)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #2;
    tickCnt++;
    tickEn = ((tickCnt % tickDiv) == 0);
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    while (phase != 3'd0) @(negedge clk);
  endtask

  task automatic waitStart();
    while (frameStart !== 1'b1) @(negedge clk);
  endtask

  // called at a negedge where frameStart is high; counts until the next frameStart
  task automatic measure();
    cE = 0; cO = 0; cR = 0; cD = 0; strobes = 0; ticks = 0; cycles = 0;
    bitSeen = bitModeOut;
    do begin
      case (phase)
        3'd1: cE++;
        3'd2: cO++;
        3'd3: cR++;
        3'd4: cD++;
        default: ;
      endcase
      strobes += int'(lineStrobe);
      if (phase == 3'd4 && tickEn) ticks++;
      cycles++;
      @(negedge clk);
    end while (frameStart !== 1'b1);
  endtask

  task automatic writeOvh(int v);
    ovhWe = 1'b1; ovhWdata = 8'(v);
    @(negedge clk);
    ovhWe = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nErr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phase in reset", int'(phase), 0);
    chk("R1 frameStart in reset", int'(frameStart), 0);
    chk("R1 lineStrobe in reset", int'(lineStrobe), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'(phase), 0);

    // table walk: R1 default overhead (vector 0), R3..R6, R10, R7 streaming total
    foreach (VEC[i]) begin
      int e, o, r, d, ratio;
      waitIdle();
      expCycles  = 20'(VEC[i][0]);
      outMode    = 3'(VEC[i][3]);
      lineCount  = 12'(VEC[i][4]);
      trigPeriod = 16'(VEC[i][5]);
      if (VEC[i][1] != 0) writeOvh(VEC[i][2]);
      runEn = 1'b1;
      @(negedge clk);
      chk("R2 frameStart after runEn", int'(frameStart), 1);
      waitStart();
      measure();
      ratio = 1 << VEC[i][3];
      e = (VEC[i][0] == 0) ? 1 : VEC[i][0];
      o = (VEC[i][2] + 2 * ratio) * 129;
      r = (VEC[i][4] == 0) ? 1 : VEC[i][4] * 129 * ratio;
      d = (VEC[i][5] == 0) ? 1 : VEC[i][5];
      chk("R3 exposure length", cE, e);
      chk(i == 0 ? "R1 R4 overhead with reset value" : "R4 R10 overhead length", cO, o);
      chk("R5 readout length", cR, r);
      chk("R5 line strobes", strobes, VEC[i][4]);
      chk("R6 delay length", cD, d);
      chk("R7 back-to-back frame period", cycles, VEC[i][6]);
      runEn = 1'b0;
    end

    // R6 sparse tick: delay closes on the trigPeriod-th tick
    waitIdle();
    tickDiv = 3;
    expCycles = 20'd2; outMode = 3'd0; lineCount = 12'd1; trigPeriod = 16'd2;
    runEn = 1'b1;
    waitStart();
    measure();
    chk("R6 ticks seen in delay", ticks, 2);
    chk("R6 delay spans sparse ticks", int'(cD >= 2 && cD <= 6), 1);
    runEn = 1'b0;
    waitIdle();
    tickDiv = 1;

    // R8 / R9 capture at frame start, R7 stop after current frame
    expCycles = 20'd30; lineCount = 12'd1; trigPeriod = 16'd1; bitModeIn = 1'b0;
    runEn = 1'b1;
    waitStart();
    expCycles = 20'd4; lineCount = 12'd2; bitModeIn = 1'b1;
    measure();
    chk("R8 exposure kept mid-frame", cE, 30);
    chk("R8 lines kept mid-frame", strobes, 1);
    chk("R9 bit mode kept mid-frame", int'(bitSeen), 0);
    measure();
    chk("R8 new exposure next frame", cE, 4);
    chk("R8 new lines next frame", strobes, 2);
    chk("R9 bit mode updated next frame", int'(bitSeen), 1);
    runEn = 1'b0;
    begin
      int c = 0;
      while (phase != 3'd0) begin c++; @(negedge clk); end
      chk("R7 frame completes after runEn drop", c, 908);
    end
    begin
      int bad = 0;
      for (int k = 0; k < 50; k++) begin
        if (phase != 3'd0 || frameStart) bad++;
        @(negedge clk);
      end
      chk("R7 stays idle without runEn", bad, 0);
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule